// File: doc/BRIEF.md
# Inclusive L2 Snoop Filter

This block keeps the coherence bookkeeping of a second-level cache that holds a superset of the first-level cache. Because every L1 line is also present in L2, only L2 watches the shared interconnect. For each L2 line it tracks a coherence state (invalid, shared, exclusive-clean, modified), a line tag, one data word, a bit saying the line is also held in L1, and a bit saying L1 holds newer data than L2. It answers snooped bus reads and read-exclusives, records L1 fills, L1 evictions and L1 write hits, and sends back-invalidate and data-recall requests down to L1 only when needed.

The directory is direct-mapped: the low `IDX_W` address bits pick the entry and the rest form the tag. An L2 fill into an occupied entry replaces the old line. Snoop and CPU-side requests are held valid until their one-cycle `*_done` pulse. A snoop wins over a CPU-side request presented in the same cycle. A data recall is a one-cycle request. L1 answers it later with `l1_rcl_ack` and the current data.

Top module: `incl_snoop_filter`

## Requirements
- R1: After reset every entry is invalid, so a snoop reports `snp_hit`=0 and an L1 fill (cpu_op 1) is refused with `cpu_ok`=0. All done, request and valid outputs are low.
- R2: An L2 fill (cpu_op 0) installs the line as exclusive-clean when `cpu_flag`=1 and as shared when `cpu_flag`=0, with `cpu_wdata` as its data. An L1 fill (cpu_op 1) that hits in L2 marks the line present in L1 and returns its data on `cpu_rdata` with `cpu_ok`=1.
- R3: An L1 write hit (cpu_op 3) is accepted (`cpu_ok`=1) only when the line is in L2, present in L1, and exclusive-clean or modified. It then moves the line to modified and marks the L2 copy stale. Otherwise it is refused and nothing changes.
- R4: A snoop that misses, or hits a line not present in L1, issues no back-invalidate and no recall to L1.
- R5: A read-exclusive snoop (`snp_excl`=1) that hits invalidates the entry. If the line was present in L1, `l1_inv_req` pulses with the line address in the same cycle as `snp_done`.
- R6: A read snoop that hits downgrades the line to shared. Only a modified line is flushed: `snp_flush`=1 and its data is on `snp_data`. A read-exclusive hit on a modified line also flushes.
- R7: A snoop that hits a stale line first pulses `l1_rcl_req` with the line address, waits for `l1_rcl_ack`, and flushes the recalled data. The stale mark is cleared.
- R8: An L1 eviction (cpu_op 2) of a line present in L1 clears the present-in-L1 mark with `cpu_ok`=1. With `cpu_flag`=1 (dirty) it also stores `cpu_wdata` and clears the stale mark. Evicting a line that is not present in L1 is refused.
- R9: An L2 fill that replaces a valid line back-invalidates the victim address if the victim was present in L1. A modified victim is written back through `wb_valid`/`wb_addr`/`wb_data`. A stale victim is recalled first, and the recalled data is written back. These outputs pulse together with `cpu_done`.
- R10: When a snoop and a CPU-side request are both valid in the same cycle, the snoop completes first.
- R11: An L2 fill of an address already present is refused (`cpu_ok`=0) and leaves the line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_valid | input | 1 | Snooped bus request present, held until snp_done |
| snp_excl | input | 1 | 1 = read-exclusive, 0 = read |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_done | output | 1 | One-cycle snoop completion |
| snp_hit | output | 1 | Snoop found the line |
| snp_flush | output | 1 | Line flushed onto the bus |
| snp_data | output | DATA_W | Flushed data |
| cpu_valid | input | 1 | CPU-side request present, held until cpu_done |
| cpu_op | input | 2 | 0 L2 fill, 1 L1 fill, 2 L1 eviction, 3 L1 write hit |
| cpu_addr | input | ADDR_W | Line address |
| cpu_wdata | input | DATA_W | Fill or eviction data |
| cpu_flag | input | 1 | Exclusive for L2 fill, dirty for L1 eviction |
| cpu_done | output | 1 | One-cycle request completion |
| cpu_ok | output | 1 | Request accepted |
| cpu_rdata | output | DATA_W | Data returned for an L1 fill |
| l1_inv_req | output | 1 | Back-invalidate pulse to L1 |
| l1_inv_addr | output | ADDR_W | Address to invalidate in L1 |
| l1_rcl_req | output | 1 | Data-recall pulse to L1 |
| l1_rcl_addr | output | ADDR_W | Address to recall |
| l1_rcl_ack | input | 1 | L1 recall answer valid |
| l1_rcl_data | input | DATA_W | Current data from L1 |
| wb_valid | output | 1 | Victim write-back to memory |
| wb_addr | output | ADDR_W | Write-back address |
| wb_data | output | DATA_W | Write-back data |

## Verification
The bench makes L1 write data that L2 has not seen, then snoops the line. A design that skipped the recall would flush the old L2 word instead of the L1 value. It replaces a stale, L1-held victim and expects recall, write-back of the L1 value and a back-invalidate together. Dropping any of the three would leave memory stale or break inclusion. Write hits on shared lines and on lines absent from L1, evictions of lines not held, and snoops of lines L1 does not hold must all stay silent or be refused. A design that ignored the present-in-L1 mark would send stray invalidates or accept illegal writes. A snoop and an eviction of the same line arrive together. A design with the wrong priority would accept the eviction and then snoop without invalidating L1.

// File: rtl/incl_snoop_filter.sv
module incl_snoop_filter #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  logic              snp_excl,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_done,
  output logic              snp_hit,
  output logic              snp_flush,
  output logic [DATA_W-1:0] snp_data,
  input  logic              cpu_valid,
  input  logic [1:0]        cpu_op,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_flag,
  output logic              cpu_done,
  output logic              cpu_ok,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              l1_inv_req,
  output logic [ADDR_W-1:0] l1_inv_addr,
  output logic              l1_rcl_req,
  output logic [ADDR_W-1:0] l1_rcl_addr,
  input  logic              l1_rcl_ack,
  input  logic [DATA_W-1:0] l1_rcl_data,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = ADDR_W - IDX_W;

  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3;
  localparam logic [1:0] OP_L2FILL = 2'd0, OP_L1FILL = 2'd1, OP_L1EVICT = 2'd2, OP_L1WRHIT = 2'd3;

  typedef enum logic [1:0] {F_IDLE, F_WAIT, F_DONE} fsm_t;
  fsm_t fsm;

  logic [1:0]        st  [ENTRIES];
  logic [TAG_W-1:0]  tg  [ENTRIES];
  logic [DATA_W-1:0] dat [ENTRIES];
  logic              in1 [ENTRIES];
  logic              stl [ENTRIES];

  logic              p_snp, p_excl, p_flag;
  logic [1:0]        p_op;
  logic [ADDR_W-1:0] p_addr;
  logic [DATA_W-1:0] p_wdata;

  logic              idle, act_snp, act_excl, act_flag, go, need_rcl;
  logic [1:0]        act_op;
  logic [ADDR_W-1:0] cur_addr, vic_addr;
  logic [DATA_W-1:0] act_wdata, fresh;
  logic [IDX_W-1:0]  cur_idx;
  logic [TAG_W-1:0]  cur_tag;
  logic [1:0]        e_st;
  logic              e_vld, e_hit, e_in1, e_stl;

  assign idle      = (fsm == F_IDLE);
  assign act_snp   = idle ? snp_valid : p_snp;
  assign act_excl  = idle ? snp_excl  : p_excl;
  assign act_op    = idle ? cpu_op    : p_op;
  assign act_flag  = idle ? cpu_flag  : p_flag;
  assign act_wdata = idle ? cpu_wdata : p_wdata;
  assign cur_addr  = idle ? (snp_valid ? snp_addr : cpu_addr) : p_addr;
  assign cur_idx   = cur_addr[IDX_W-1:0];
  assign cur_tag   = cur_addr[ADDR_W-1:IDX_W];

  assign e_st     = st[cur_idx];
  assign e_vld    = (e_st != ST_I);
  assign e_hit    = e_vld && (tg[cur_idx] == cur_tag);
  assign e_in1    = in1[cur_idx];
  assign e_stl    = stl[cur_idx];
  assign vic_addr = {tg[cur_idx], cur_idx};
  assign fresh    = (fsm == F_WAIT) ? l1_rcl_data : dat[cur_idx];

  assign go = (idle && (snp_valid || cpu_valid)) || (fsm == F_WAIT && l1_rcl_ack);
  assign need_rcl = idle && e_stl &&
                    ((act_snp && e_hit) ||
                     (!act_snp && act_op == OP_L2FILL && !e_hit && e_vld));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm <= F_IDLE;
      for (int i = 0; i < ENTRIES; i++) begin
        st[i]  <= ST_I;
        tg[i]  <= '0;
        dat[i] <= '0;
        in1[i] <= 1'b0;
        stl[i] <= 1'b0;
      end
      p_snp <= 1'b0; p_excl <= 1'b0; p_flag <= 1'b0; p_op <= '0;
      p_addr <= '0; p_wdata <= '0;
      snp_done <= 1'b0; snp_hit <= 1'b0; snp_flush <= 1'b0; snp_data <= '0;
      cpu_done <= 1'b0; cpu_ok <= 1'b0; cpu_rdata <= '0;
      l1_inv_req <= 1'b0; l1_inv_addr <= '0;
      l1_rcl_req <= 1'b0; l1_rcl_addr <= '0;
      wb_valid <= 1'b0; wb_addr <= '0; wb_data <= '0;
    end else begin
      snp_done <= 1'b0; snp_hit <= 1'b0; snp_flush <= 1'b0;
      cpu_done <= 1'b0; cpu_ok <= 1'b0;
      l1_inv_req <= 1'b0; l1_rcl_req <= 1'b0; wb_valid <= 1'b0;
      if (fsm == F_DONE) fsm <= F_IDLE;

      if (go && need_rcl) begin
        p_snp <= act_snp; p_excl <= act_excl; p_op <= act_op; p_flag <= act_flag;
        p_addr <= cur_addr; p_wdata <= act_wdata;
        l1_rcl_req  <= 1'b1;
        l1_rcl_addr <= act_snp ? cur_addr : vic_addr;
        fsm <= F_WAIT;
      end else if (go) begin
        fsm <= F_DONE;
        if (act_snp) begin
          snp_done <= 1'b1;
          snp_hit  <= e_hit;
          if (e_hit) begin
            dat[cur_idx] <= fresh;
            stl[cur_idx] <= 1'b0;
            if (e_st == ST_M) begin
              snp_flush <= 1'b1;
              snp_data  <= fresh;
            end
            if (act_excl) begin
              st[cur_idx]  <= ST_I;
              in1[cur_idx] <= 1'b0;
              if (e_in1) begin
                l1_inv_req  <= 1'b1;
                l1_inv_addr <= cur_addr;
              end
            end else begin
              st[cur_idx] <= ST_S;
            end
          end
        end else begin
          cpu_done <= 1'b1;
          case (act_op)
            OP_L2FILL: if (!e_hit) begin
              cpu_ok <= 1'b1;
              if (e_vld && e_st == ST_M) begin
                wb_valid <= 1'b1;
                wb_addr  <= vic_addr;
                wb_data  <= fresh;
              end
              if (e_vld && e_in1) begin
                l1_inv_req  <= 1'b1;
                l1_inv_addr <= vic_addr;
              end
              st[cur_idx]  <= act_flag ? ST_E : ST_S;
              tg[cur_idx]  <= cur_tag;
              dat[cur_idx] <= act_wdata;
              in1[cur_idx] <= 1'b0;
              stl[cur_idx] <= 1'b0;
            end
            OP_L1FILL: if (e_hit) begin
              cpu_ok       <= 1'b1;
              cpu_rdata    <= dat[cur_idx];
              in1[cur_idx] <= 1'b1;
            end
            OP_L1EVICT: if (e_hit && e_in1) begin
              cpu_ok       <= 1'b1;
              in1[cur_idx] <= 1'b0;
              if (act_flag) begin
                dat[cur_idx] <= act_wdata;
                stl[cur_idx] <= 1'b0;
              end
            end
            default: if (e_hit && e_in1 && (e_st == ST_E || e_st == ST_M)) begin
              cpu_ok       <= 1'b1;
              st[cur_idx]  <= ST_M;
              stl[cur_idx] <= 1'b1;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/incl_snoop_filter_chk.sv
module incl_snoop_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic snp_done,
  input logic snp_hit,
  input logic snp_flush,
  input logic cpu_done,
  input logic cpu_ok,
  input logic l1_inv_req,
  input logic l1_rcl_req,
  input logic wb_valid
);
  // R4: a missing snoop never reaches L1
  a_r4_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_done && !snp_hit) |-> !l1_inv_req);
  // R6: a flush only accompanies a completed hitting snoop
  a_r6_flush_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> (snp_done && snp_hit));
  // R7: recall is a single-cycle pulse
  a_r7_recall_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    l1_rcl_req |=> !l1_rcl_req);
  // R7: recall precedes completion, never coincides with it
  a_r7_recall_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    l1_rcl_req |-> (!snp_done && !cpu_done));
  // R9: write-back only with an accepted fill
  a_r9_wb_with_fill: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (cpu_done && cpu_ok));
  // R5: back-invalidate only with a hitting snoop or accepted request
  a_r5_inv_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    l1_inv_req |-> ((snp_done && snp_hit) || (cpu_done && cpu_ok)));
  // R5: snoop completion is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    snp_done |=> !snp_done);
  // R10: one request completes at a time
  a_r10_one_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(snp_done && cpu_done));
endmodule

bind incl_snoop_filter incl_snoop_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .snp_done(snp_done), .snp_hit(snp_hit),
  .snp_flush(snp_flush), .cpu_done(cpu_done), .cpu_ok(cpu_ok),
  .l1_inv_req(l1_inv_req), .l1_rcl_req(l1_rcl_req), .wb_valid(wb_valid)
);

// File: tb/incl_snoop_filter_tb_top.sv
module incl_snoop_filter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        snp_valid = 0, snp_excl = 0;
  logic [7:0]  snp_addr = 0;
  logic        snp_done, snp_hit, snp_flush;
  logic [15:0] snp_data;
  logic        cpu_valid = 0, cpu_flag = 0;
  logic [1:0]  cpu_op = 0;
  logic [7:0]  cpu_addr = 0;
  logic [15:0] cpu_wdata = 0;
  logic        cpu_done, cpu_ok;
  logic [15:0] cpu_rdata;
  logic        l1_inv_req, l1_rcl_req;
  logic [7:0]  l1_inv_addr, l1_rcl_addr;
  logic        l1_rcl_ack = 0;
  logic [15:0] l1_rcl_data = 0;
  logic        wb_valid;
  logic [7:0]  wb_addr;
  logic [15:0] wb_data;

  incl_snoop_filter dut_i (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_excl(snp_excl), .snp_addr(snp_addr),
    .snp_done(snp_done), .snp_hit(snp_hit), .snp_flush(snp_flush), .snp_data(snp_data),
    .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_flag(cpu_flag), .cpu_done(cpu_done), .cpu_ok(cpu_ok), .cpu_rdata(cpu_rdata),
    .l1_inv_req(l1_inv_req), .l1_inv_addr(l1_inv_addr),
    .l1_rcl_req(l1_rcl_req), .l1_rcl_addr(l1_rcl_addr),
    .l1_rcl_ack(l1_rcl_ack), .l1_rcl_data(l1_rcl_data),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  typedef struct packed {
    logic        is_snp;
    logic        ok;
    logic        flush;
    logic        chk_data;
    logic [15:0] data;
    logic        inv;
    logic [7:0]  inv_addr;
    logic        wb;
    logic [7:0]  wb_addr;
    logic [15:0] wb_data;
    logic        rcl;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk = 0, n_err = 0;
  logic  rcl_seen = 0;
  logic [15:0] l1mem [256];

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // L1 model answers a recall one cycle later with its current data
  always @(negedge clk) begin
    if (l1_rcl_req) begin
      l1_rcl_ack  = 1'b1;
      l1_rcl_data = l1mem[l1_rcl_addr];
    end else begin
      l1_rcl_ack = 1'b0;
    end
  end

  exp_t  m_e;
  string m_t;
  always @(negedge clk) begin
    if (rst_n) begin
      if (l1_rcl_req) rcl_seen = 1'b1;
      if (snp_done || cpu_done) begin
        if (exp_q.size() == 0) begin
          chk("R10", "unexpected completion", 1, 0);
        end else begin
          m_e = exp_q.pop_front();
          m_t = tag_q.pop_front();
          chk(m_t, "snoop kind", {31'd0, snp_done}, {31'd0, m_e.is_snp});
          if (m_e.is_snp) begin
            chk(m_t, "snp_hit", {31'd0, snp_hit}, {31'd0, m_e.ok});
            chk(m_t, "snp_flush", {31'd0, snp_flush}, {31'd0, m_e.flush});
            if (m_e.flush) chk(m_t, "snp_data", {16'd0, snp_data}, {16'd0, m_e.data});
          end else begin
            chk(m_t, "cpu_ok", {31'd0, cpu_ok}, {31'd0, m_e.ok});
            if (m_e.chk_data) chk(m_t, "cpu_rdata", {16'd0, cpu_rdata}, {16'd0, m_e.data});
            chk(m_t, "wb_valid", {31'd0, wb_valid}, {31'd0, m_e.wb});
            if (m_e.wb) begin
              chk(m_t, "wb_addr", {24'd0, wb_addr}, {24'd0, m_e.wb_addr});
              chk(m_t, "wb_data", {16'd0, wb_data}, {16'd0, m_e.wb_data});
            end
          end
          chk(m_t, "l1_inv_req", {31'd0, l1_inv_req}, {31'd0, m_e.inv});
          if (m_e.inv) chk(m_t, "l1_inv_addr", {24'd0, l1_inv_addr}, {24'd0, m_e.inv_addr});
          chk(m_t, "recall seen", {31'd0, rcl_seen}, {31'd0, m_e.rcl});
        end
        rcl_seen = 1'b0;
      end
    end
  end

  task automatic exp_snp(input logic hit, input logic flush, input logic [15:0] data,
                         input logic inv, input logic [7:0] ia, input logic rcl, input string tag);
    exp_t e;
    e = '0;
    e.is_snp = 1; e.ok = hit; e.flush = flush; e.data = data;
    e.inv = inv; e.inv_addr = ia; e.rcl = rcl;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic exp_cpu(input logic ok, input logic chkd, input logic [15:0] data,
                         input logic inv, input logic [7:0] ia, input logic wb,
                         input logic [15:0] wd, input logic rcl, input string tag);
    exp_t e;
    e = '0;
    e.ok = ok; e.chk_data = chkd; e.data = data; e.inv = inv; e.inv_addr = ia;
    e.wb = wb; e.wb_addr = ia; e.wb_data = wd; e.rcl = rcl;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic snoop(input logic excl, input logic [7:0] a, input logic hit, input logic flush,
                       input logic [15:0] data, input logic inv, input logic rcl, input string tag);
    exp_snp(hit, flush, data, inv, a, rcl, tag);
    @(negedge clk);
    snp_valid = 1; snp_excl = excl; snp_addr = a;
    do @(negedge clk); while (!snp_done);
    snp_valid = 0;
  endtask

  task automatic cpu(input logic [1:0] op, input logic [7:0] a, input logic [15:0] wd, input logic flag,
                     input logic ok, input logic chkd, input logic [15:0] rd, input logic inv,
                     input logic [7:0] ia, input logic wb, input logic [15:0] wbd, input logic rcl,
                     input string tag);
    exp_cpu(ok, chkd, rd, inv, ia, wb, wbd, rcl, tag);
    @(negedge clk);
    cpu_valid = 1; cpu_op = op; cpu_addr = a; cpu_wdata = wd; cpu_flag = flag;
    do @(negedge clk); while (!cpu_done);
    cpu_valid = 0;
  endtask

  localparam logic [1:0] L2F = 0, L1F = 1, EVT = 2, WRH = 3;
  localparam logic [7:0] A = 8'h10, B = 8'h21, C = 8'h14, D = 8'h32, E = 8'h23, F = 8'h36;

  initial begin
    repeat (20000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=hung expected=complete");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) l1mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: idle outputs after reset
    chk("R1", "snp_done", {31'd0, snp_done}, 0);
    chk("R1", "cpu_done", {31'd0, cpu_done}, 0);
    chk("R1", "l1_inv_req", {31'd0, l1_inv_req}, 0);
    chk("R1", "l1_rcl_req", {31'd0, l1_rcl_req}, 0);
    chk("R1", "wb_valid", {31'd0, wb_valid}, 0);

    snoop(0, A, 0, 0, 0, 0, 0, "R1");
    cpu(L1F, A, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    cpu(L2F, A, 16'h1111, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R2");
    cpu(L2F, A, 16'h9999, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R11");
    cpu(L1F, A, 0, 0, 1, 1, 16'h1111, 0, 0, 0, 0, 0, "R2");
    cpu(WRH, A, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R3");
    l1mem[A] = 16'hAAAA;
    snoop(0, A, 1, 1, 16'hAAAA, 0, 1, "R7");
    cpu(WRH, A, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
    snoop(0, A, 1, 0, 0, 0, 0, "R6");
    snoop(1, A, 1, 0, 0, 1, 0, "R5");
    snoop(0, A, 0, 0, 0, 0, 0, "R5");

    cpu(L2F, B, 16'h2222, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R2");
    cpu(L1F, B, 0, 0, 1, 1, 16'h2222, 0, 0, 0, 0, 0, "R2");
    cpu(WRH, B, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
    cpu(L2F, D, 16'h3333, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R2");
    cpu(WRH, D, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
    snoop(1, D, 1, 0, 0, 0, 0, "R4");

    cpu(L2F, E, 16'h4444, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R2");
    cpu(L1F, E, 0, 0, 1, 1, 16'h4444, 0, 0, 0, 0, 0, "R2");
    snoop(0, E, 1, 0, 0, 0, 0, "R6");
    cpu(WRH, E, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6");

    cpu(EVT, B, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R8");
    cpu(EVT, B, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    snoop(1, B, 1, 0, 0, 0, 0, "R8");

    cpu(L2F, A, 16'h5555, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R8");
    cpu(L1F, A, 0, 0, 1, 1, 16'h5555, 0, 0, 0, 0, 0, "R8");
    cpu(WRH, A, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R8");
    cpu(EVT, A, 16'hBEEF, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R8");
    snoop(0, A, 1, 1, 16'hBEEF, 0, 0, "R8");

    snoop(1, A, 1, 0, 0, 0, 0, "R9");
    cpu(L2F, A, 16'h6666, 1, 1, 0, 0, 0, 0, 0, 0, 0, "R9");
    cpu(L1F, A, 0, 0, 1, 1, 16'h6666, 0, 0, 0, 0, 0, "R9");
    cpu(WRH, A, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R9");
    l1mem[A] = 16'hC0DE;
    cpu(L2F, C, 16'h7777, 1, 1, 0, 0, 1, A, 1, 16'hC0DE, 1, "R9");
    snoop(0, C, 1, 0, 0, 0, 0, "R9");
    snoop(0, A, 0, 0, 0, 0, 0, "R9");

    cpu(L2F, D, 16'h3333, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R9");
    cpu(L1F, D, 0, 0, 1, 1, 16'h3333, 0, 0, 0, 0, 0, "R9");
    cpu(L2F, F, 16'h8888, 1, 1, 0, 0, 1, D, 0, 0, 0, "R9");

    // R10: snoop and eviction of the same line arrive together
    exp_snp(1, 0, 0, 1, E, 0, "R10");
    exp_cpu(0, 0, 0, 0, 0, 0, 0, 0, "R10");
    @(negedge clk);
    snp_valid = 1; snp_excl = 1; snp_addr = E;
    cpu_valid = 1; cpu_op = EVT; cpu_addr = E; cpu_wdata = 0; cpu_flag = 0;
    do @(negedge clk); while (!snp_done);
    snp_valid = 0;
    do @(negedge clk); while (!cpu_done);
    cpu_valid = 0;

    repeat (4) @(negedge clk);
    chk("R10", "pending expectations", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule